// File: doc/BRIEF.md
# Low-Power STOP Entry and Wake Controller

This block puts the chip into a STOP state, in which the core clock is held off, and brings it back out. Software starts STOP through a small control register. Bit 1 of the write data requests entry. Bit 0 selects how the dedicated wake pin releases the state: 1 means level-sensitive release and 0 means edge-sensitive release. The wake pin passes through a two-flop synchronizer before any detection. A 2-bit release-source field enables pin release only for the codes 00 and 10.

On release, a warm-up timer counts before the core clock enable returns high. The timer runs for the programmed 8-bit count multiplied by 2^PRE_LOG2 source ticks. A count of 0 behaves as a count of 1. The ticks come from whichever oscillator drove the main clock at the moment STOP began, whatever the main-clock selection does afterwards. When the timer expires, the block drops its start bit by itself and pulses a completion flag for one cycle. A 2-bit state output shows where the sequence stands.

Top module: `stop_ctrl`

## Requirements
- R1: A control write with bit 1 set, taken in RUN, enters STOP on the next clock unless R4 applies. The register readback then shows bit 1 = 1.
- R2: Control write bit 0 is stored as the release mode: 1 = level-sensitive, 0 = edge-sensitive. It reads back on ctl_rdata[0].
- R3: In level mode with release enabled, STOP turns into WARMUP on the third rising clock edge after the pin goes high.
- R4: In level mode, a start request made while the synchronized pin is high is dropped. The block stays in RUN and readback bit 1 stays 0.
- R5: In edge mode, a pin that is high at entry does not block entry. Only a low-to-high transition of the synchronized pin seen during STOP releases the state, on the third clock edge after the pin rises.
- R6: Pin release is allowed only when rel_src is 2'b00 or 2'b10. With 2'b01 or 2'b11 the block stays in STOP.
- R7: WARMUP lasts max(wu_count,1) * 2^PRE_LOG2 ticks of the selected source (128 cycles for a count of 2 and 64 for a count of 0 with the defaults and a tick every cycle).
- R8: The warm-up tick source is tick_slow if main_from_slow was 1 at entry, otherwise tick_fast. Changes to main_from_slow after entry have no effect.
- R9: core_clk_en is 1 in RUN and 0 in STOP and WARMUP.
- R10: Leaving WARMUP sets rel_done high for exactly one cycle, in the first RUN cycle, and clears readback bit 1.
- R11: pm_state encodes RUN = 0, STOP = 1, WARMUP = 2, and reset leaves RUN with the readback equal to 0.
- R12: Control writes made outside RUN change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Bit 1 requests STOP, bit 0 selects level mode |
| ctl_rdata | output | 2 | Readback: bit 1 is the STOP bit, bit 0 is the mode |
| rel_src | input | 2 | Release-source select; 00 and 10 enable the pin |
| wu_count | input | CNT_W | Warm-up count in prescaled units |
| main_from_slow | input | 1 | Main clock currently driven by the slow oscillator |
| tick_fast | input | 1 | One-cycle tick of the fast oscillator |
| tick_slow | input | 1 | One-cycle tick of the slow oscillator |
| stop_pin | input | 1 | Asynchronous wake pin |
| core_clk_en | output | 1 | Core clock enable |
| rel_done | output | 1 | One-cycle warm-up completion pulse |
| pm_state | output | 2 | Current state: 0 RUN, 1 STOP, 2 WARMUP |

## Verification
A control write becomes visible on pm_state and ctl_rdata one clock after the strobe. A pin change becomes visible three clocks later, because of the two synchronizer flops and the state register. The warm-up ends exactly max(count,1)·2^PRE_LOG2 selected ticks after WARMUP is entered, and rel_done rises in the same clock that pm_state returns to 0. The bench drives inputs and samples outputs on falling edges. A behavioural model steps on each rising edge with the same pipeline delays and is compared against every output on every falling edge. Directed checks count falling edges between a stimulus and the state change, and compare the count with these latencies. For the slow source, the count must fall within the window allowed by the tick phase.

// File: rtl/stop_ctrl_pkg.sv
package stop_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WARM = 2'd2
  } pm_state_e;

  localparam int CTL_START_BIT = 1;
  localparam int CTL_MODE_BIT  = 0;
endpackage

// File: rtl/stop_pin_sync.sv
module stop_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_lvl,
  output logic pin_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign pin_lvl  = sync_q[SYNC_STAGES-1];
  assign pin_rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/stop_warmup_timer.sv
module stop_warmup_timer #(
  parameter int CNT_W    = 8,
  parameter int PRE_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             busy,
  output logic             expire
);
  localparam int PRE_W = (PRE_LOG2 < 1) ? 1 : PRE_LOG2;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'((1 << PRE_LOG2) - 1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == PRE_MAX);
  assign expire   = busy_q & tick & pre_wrap & (cnt_q == CNT_ONE);
  assign busy     = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    pre_d  = pre_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = (load_val == '0) ? CNT_ONE : load_val;
      pre_d  = '0;
    end else if (busy_q && tick) begin
      if (pre_wrap) begin
        pre_d = '0;
        if (cnt_q == CNT_ONE) busy_d = 1'b0;
        else                  cnt_d  = cnt_q - CNT_ONE;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      pre_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      pre_q  <= pre_d;
    end
  end

  // R8
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick && !start) |=> ($stable(cnt_q) && $stable(pre_q)));
endmodule

// File: rtl/stop_fsm.sv
module stop_fsm
  import stop_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_wdata,
  input  logic       pin_lvl,
  input  logic       pin_rise,
  input  logic [1:0] rel_src,
  input  logic       main_from_slow,
  input  logic       wu_expire,
  output pm_state_e  state,
  output logic       stop_bit,
  output logic       lvl_mode,
  output logic       src_slow,
  output logic       wu_start,
  output logic       rel_done
);
  pm_state_e state_q, state_d;
  logic stop_q, stop_d, mode_q, mode_d, src_q, src_d, done_q, done_d;
  logic req_start, req_mode, rel_ok, rel_hit;

  assign req_start = ctl_wdata[CTL_START_BIT];
  assign req_mode  = ctl_wdata[CTL_MODE_BIT];
  assign rel_ok    = ~rel_src[0];
  assign rel_hit   = rel_ok & (mode_q ? pin_lvl : pin_rise);

  always_comb begin
    state_d  = state_q;
    stop_d   = stop_q;
    mode_d   = mode_q;
    src_d    = src_q;
    done_d   = 1'b0;
    wu_start = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (ctl_wr) begin
          mode_d = req_mode;
          if (req_start && !(req_mode && pin_lvl)) begin
            state_d = ST_STOP;
            stop_d  = 1'b1;
            src_d   = main_from_slow;
          end
        end
      end
      ST_STOP: begin
        if (rel_hit) begin
          state_d  = ST_WARM;
          wu_start = 1'b1;
        end
      end
      ST_WARM: begin
        if (wu_expire) begin
          state_d = ST_RUN;
          stop_d  = 1'b0;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      stop_q  <= 1'b0;
      mode_q  <= 1'b0;
      src_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= stop_d;
      mode_q  <= mode_d;
      src_q   <= src_d;
      done_q  <= done_d;
    end
  end

  assign state    = state_q;
  assign stop_bit = stop_q;
  assign lvl_mode = mode_q;
  assign src_slow = src_q;
  assign rel_done = done_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_RUN && !stop_q && !done_d));
  // R4
  lvl_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && ctl_wr && req_start && req_mode && pin_lvl) |=> (state_q == ST_RUN));
  // R6
  src_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && rel_src[0]) |=> (state_q == ST_STOP));
  // R3
  stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |=> (state_q != ST_RUN));
  // R12
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN) |=> ($stable(mode_q) && $stable(src_q)));
endmodule

// File: rtl/stop_ctrl.sv
module stop_ctrl
  import stop_ctrl_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_LOG2    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [1:0]       ctl_wdata,
  output logic [1:0]       ctl_rdata,
  input  logic [1:0]       rel_src,
  input  logic [CNT_W-1:0] wu_count,
  input  logic             main_from_slow,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic             stop_pin,
  output logic             core_clk_en,
  output logic             rel_done,
  output logic [1:0]       pm_state
);
  logic      pin_lvl, pin_rise;
  logic      stop_bit, lvl_mode, src_slow, wu_start, wu_busy, wu_expire, wu_tick;
  pm_state_e state;

  stop_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(stop_pin),
    .pin_lvl(pin_lvl), .pin_rise(pin_rise)
  );

  stop_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .pin_lvl(pin_lvl), .pin_rise(pin_rise), .rel_src(rel_src),
    .main_from_slow(main_from_slow), .wu_expire(wu_expire),
    .state(state), .stop_bit(stop_bit), .lvl_mode(lvl_mode),
    .src_slow(src_slow), .wu_start(wu_start), .rel_done(rel_done)
  );

  assign wu_tick = src_slow ? tick_slow : tick_fast;

  stop_warmup_timer #(.CNT_W(CNT_W), .PRE_LOG2(PRE_LOG2)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(wu_start), .load_val(wu_count),
    .tick(wu_tick), .busy(wu_busy), .expire(wu_expire)
  );

  assign core_clk_en = (state == ST_RUN);
  assign pm_state    = state;
  assign ctl_rdata   = {stop_bit, lvl_mode};

  // R7
  warm_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WARM) |-> wu_busy);
endmodule

// File: tb/tb_stop_ctrl.sv
`timescale 1ns/1ps
module tb_stop_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic ctl_wr;
  logic [1:0] ctl_wdata, ctl_rdata, rel_src, pm_state;
  logic [7:0] wu_count;
  logic main_from_slow, tick_fast, tick_slow, stop_pin, core_clk_en, rel_done;

  int checks = 0, errors = 0, slow_div = 0;
  int m_state, m_stop, m_mode, m_src, m_left, m_done, p1, p2, p3;
  int n, dn;

  always #4 clk = ~clk;

  stop_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .rel_src(rel_src), .wu_count(wu_count),
    .main_from_slow(main_from_slow), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .stop_pin(stop_pin), .core_clk_en(core_clk_en), .rel_done(rel_done),
    .pm_state(pm_state)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, stepped on each rising edge
  always @(posedge clk) begin
    int nstate, nstop, nmode, nsrc, nleft, ndone, tk;
    if (!rst_n) begin
      m_state = 0; m_stop = 0; m_mode = 0; m_src = 0; m_left = 0; m_done = 0;
      p1 = 0; p2 = 0; p3 = 0;
    end else begin
      nstate = m_state; nstop = m_stop; nmode = m_mode; nsrc = m_src;
      nleft = m_left; ndone = 0;
      if (m_state == 0) begin
        if (ctl_wr) begin
          nmode = ctl_wdata[0];
          if (ctl_wdata[1] && !(ctl_wdata[0] && p2 == 1)) begin
            nstate = 1; nstop = 1; nsrc = main_from_slow;
          end
        end
      end else if (m_state == 1) begin
        if ((rel_src == 2'b00 || rel_src == 2'b10) &&
            (m_mode == 1 ? p2 == 1 : (p2 == 1 && p3 == 0))) begin
          nstate = 2;
          nleft = ((wu_count == 0) ? 1 : int'(wu_count)) * 64;
        end
      end else begin
        tk = m_src ? tick_slow : tick_fast;
        if (tk != 0) begin
          nleft = m_left - 1;
          if (nleft == 0) begin nstate = 0; nstop = 0; ndone = 1; end
        end
      end
      m_state = nstate; m_stop = nstop; m_mode = nmode; m_src = nsrc;
      m_left = nleft; m_done = ndone;
      p3 = p2; p2 = p1; p1 = stop_pin;
    end
  end

  // per-cycle comparison and slow tick generation on falling edges
  always @(negedge clk) begin
    slow_div = (slow_div + 1) % 4;
    tick_slow <= (slow_div == 3);
    if (rst_n) begin
      chk(pm_state == m_state[1:0], "R11 pm_state vs model", pm_state, m_state);
      chk(core_clk_en == (m_state == 0), "R9 core_clk_en vs model", core_clk_en, m_state == 0);
      chk(rel_done == m_done[0], "R10 rel_done vs model", rel_done, m_done);
      chk(ctl_rdata == {m_stop[0], m_mode[0]}, "R2 ctl_rdata vs model", ctl_rdata, m_stop * 2 + m_mode);
    end
  end

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input bit st, input bit lv);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = {st, lv};
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_leave(input int from, output int cnt, output int dones);
    cnt = 0; dones = 0;
    while (pm_state == from[1:0] && cnt < 2000) begin
      @(negedge clk);
      cnt++;
      if (rel_done) dones++;
    end
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = 2'b00; rel_src = 2'b00;
    wu_count = 8'd2; main_from_slow = 1'b0; tick_fast = 1'b1; tick_slow = 1'b0;
    stop_pin = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk(pm_state == 2'd0 && ctl_rdata == 2'b00, "R11 reset state", pm_state, 0);
    chk(core_clk_en == 1'b1, "R9 clock enabled after reset", core_clk_en, 1);

    // level mode, pin high: request dropped
    stop_pin = 1'b1; cyc(4);
    wr(1'b1, 1'b1);
    chk(pm_state == 2'd0, "R4 start ignored while pin high", pm_state, 0);
    chk(ctl_rdata == 2'b01, "R2 level mode stored, R4 start bit clear", ctl_rdata, 1);

    // level mode, pin low: enter, then release
    stop_pin = 1'b0; cyc(4);
    wr(1'b1, 1'b1);
    chk(pm_state == 2'd1, "R1 STOP entered", pm_state, 1);
    chk(ctl_rdata == 2'b11, "R1 start bit set", ctl_rdata, 3);
    chk(core_clk_en == 1'b0, "R9 clock off in STOP", core_clk_en, 0);
    wr(1'b0, 1'b0);
    chk(ctl_rdata == 2'b11 && pm_state == 2'd1, "R12 write in STOP ignored", ctl_rdata, 3);
    stop_pin = 1'b1;
    wait_leave(1, n, dn);
    chk(n == 3, "R3 level release latency", n, 3);
    chk(pm_state == 2'd2 && core_clk_en == 1'b0, "R9 clock off in WARMUP", pm_state, 2);
    wait_leave(2, n, dn);
    chk(n == 128, "R7 warm-up length count 2", n, 128);
    chk(dn == 1 && rel_done == 1'b1, "R10 done pulse on return", dn, 1);
    chk(ctl_rdata == 2'b01, "R10 start bit cleared", ctl_rdata, 1);
    cyc(1);
    chk(rel_done == 1'b0, "R10 done lasts one cycle", rel_done, 0);

    // edge mode, slow source, pin high at entry
    main_from_slow = 1'b1; wu_count = 8'd1;
    wr(1'b1, 1'b0);
    chk(pm_state == 2'd1, "R5 entry not blocked by high pin", pm_state, 1);
    main_from_slow = 1'b0;
    cyc(10);
    chk(pm_state == 2'd1, "R5 steady high pin does not release", pm_state, 1);
    rel_src = 2'b01; stop_pin = 1'b0; cyc(4); stop_pin = 1'b1; cyc(6);
    chk(pm_state == 2'd1, "R6 rel_src 01 blocks release", pm_state, 1);
    rel_src = 2'b10; stop_pin = 1'b0; cyc(4); stop_pin = 1'b1;
    wait_leave(1, n, dn);
    chk(n == 3, "R5 edge release latency with rel_src 10", n, 3);
    wait_leave(2, n, dn);
    chk(n >= 253 && n <= 256, "R8 warm-up on captured slow source", n, 256);

    // level mode, rel_src 11 blocks, count 0
    stop_pin = 1'b0; rel_src = 2'b00; wu_count = 8'd0; cyc(4);
    wr(1'b1, 1'b1);
    chk(pm_state == 2'd1, "R1 STOP entered again", pm_state, 1);
    rel_src = 2'b11; stop_pin = 1'b1; cyc(8);
    chk(pm_state == 2'd1, "R6 rel_src 11 blocks release", pm_state, 1);
    rel_src = 2'b00;
    wait_leave(1, n, dn);
    chk(n == 1, "R6 release once rel_src 00", n, 1);
    wait_leave(2, n, dn);
    chk(n == 64, "R7 count 0 acts as 1", n, 64);
    cyc(3);
    summary();
  end
endmodule